// File: doc/BRIEF.md
# Cascadable Programmable Tap Delay Line

This block delays a single-bit signal by a programmable number of clock cycles. One clock cycle is the smallest delay step and stands for a quarter of a basic gate delay. A 7-bit binary select picks the delay above a fixed minimum. An eighth select bit does not affect the delay. It drives a complementary cascade output pair, so that two or more stages can share one select bus and be chained into a longer line. The delay line itself is a shift register. A multiplexer reads it at the tap that the stored control word selects.

The select bits pass through a control register. While the hold input is low the register reloads every cycle, and while the hold input is high it keeps its value. Two override inputs take priority over both the hold input and the select bus. The force-low override clears the whole register and gives the minimum delay. The force-high override loads a fixed top pattern and adds one more gate step, so the stage reaches its largest delay. To chain two stages, the first stage's true cascade output drives its own force-high input, and its inverted cascade output drives the force-low input of the next stage. Seen through the extended 8-bit code, the pair then steps by exactly one unit for each code value. An input enable holds the output low while it is deasserted.

Top module: `tapdl_stage`

## Requirements
- R1: With enable high and no override active, the output equals the input from MIN_DLY plus W cycles earlier. W is the sum of 2^i over the set bits i of select bits [6:0]: bit 0 adds 1 unit and bit 6 adds 64 units. A new select value takes effect after one clock edge.
- R2: Select bits [6:0] all set give a delay of MIN_DLY+127. No setting gives a delay outside the range MIN_DLY to MIN_DLY+128.
- R3: When the hold input is low, the control register loads the select bus at every edge. When the hold input is high and no override is active, the stored word and the delay stay unchanged whatever the select bus does.
- R4: Select bit 7 is stored like the other bits but adds no delay. cas_o equals the stored bit 7 one edge after it is loaded, and cas_n_o is always its complement.
- R5: force_min_i clears all eight stored bits, including the cascade bit. The delay becomes MIN_DLY, and neither the select bus nor the hold input has any effect. The cleared word stays after release while hold is high.
- R6: force_max_i with force_min_i low clears stored bits 0 and 1, sets bits 2 to 6, and adds 4 extra units, for a delay of MIN_DLY+128 regardless of the select bus. Stored bit 7 keeps following the normal load/hold path, so a stage that drives its own force-high input from cas_o can still leave the maximum setting. force_min_i wins when both are high.
- R7: While en_i is low, dout_o is low from the next edge on. After en_i returns high, the output follows the delayed input again.
- R8: Synchronous reset clears the control register, the delay line and the output. After reset the delay is MIN_DLY, cas_o is 0 and cas_n_o is 1.
- R9: Two chained stages driven by an 8-bit extended code c give a total delay of 2*MIN_DLY+c for every c from 0 to 255. The total therefore rises by exactly one unit per code step, including across the step from 127 to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one delay unit |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Signal enable; output held low when low |
| din_i | input | 1 | Signal to be delayed |
| len_i | input | 1 | Control hold: low loads the select bus, high keeps the stored word |
| force_min_i | input | 1 | Override to minimum delay, clears all stored bits |
| force_max_i | input | 1 | Override to maximum delay pattern plus one extra gate step |
| sel_i | input | 8 | Bits [6:0] delay code, bit 7 cascade request |
| dout_o | output | 1 | Delayed signal |
| cas_o | output | 1 | Stored cascade bit |
| cas_n_o | output | 1 | Complement of cas_o |

## Verification
A wrong stored control word shows at the ports as a pulse that arrives a whole number of units early or late. The error equals the weight of the wrong bit, so a pulse timed through the line exposes it within MIN_DLY+128 cycles. A stored cascade bit that is wrong appears on cas_o and cas_n_o one edge after loading. In a chain it also moves the total delay by about 128 units, which the full sweep of the extended code turns into a break in the one-unit-per-step sequence. A leaky enable gate or a bad override priority shows up as a pulse in a window where the output should stay low, or as a delay that moves with the select bus when it should be fixed.

// File: rtl/tapdl_pkg.sv
package tapdl_pkg;

    // Width of the binary delay code and of the stored control word
    localparam int SEL_W    = 7;
    localparam int CTRL_W   = SEL_W + 1;
    localparam int CAS_BIT  = SEL_W;

    // Force-high clears this many low code bits and adds one gate step
    localparam int FMAX_CLR    = 2;
    localparam int EXTRA_UNITS = 1 << FMAX_CLR;

    // Largest reachable code weight (force-high pattern plus extra step)
    localparam int MAX_UNITS = ((1 << SEL_W) - 1) - ((1 << FMAX_CLR) - 1) + EXTRA_UNITS;

    typedef struct packed {
        logic              maxed;
        logic [CTRL_W-1:0] bits;
    } ctrl_t;

    typedef enum logic [1:0] {
        BIT_LOAD = 2'd0,
        BIT_HOLD = 2'd1,
        BIT_CLR  = 2'd2,
        BIT_SET  = 2'd3
    } bit_act_e;

    // Next action for one stored control bit; overrides beat the hold input
    function automatic bit_act_e bit_action(input int idx, input logic len,
                                            input logic fmin, input logic fmax);
        if (fmin)
            return BIT_CLR;
        if (fmax && idx < SEL_W)
            return (idx < FMAX_CLR) ? BIT_CLR : BIT_SET;
        if (len)
            return BIT_HOLD;
        return BIT_LOAD;
    endfunction

    // Binary weight of the delay code in units
    function automatic int unsigned code_weight(input logic [SEL_W-1:0] code);
        int unsigned acc;
        acc = 0;
        for (int i = 0; i < SEL_W; i++)
            if (code[i])
                acc += (1 << i);
        return acc;
    endfunction

endpackage

// File: rtl/tapdl_ctrl_latch.sv
module tapdl_ctrl_latch
    import tapdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              len_i,
    input  logic              fmin_i,
    input  logic              fmax_i,
    input  logic [CTRL_W-1:0] sel_i,
    output ctrl_t             ctrl_o
);

    logic [CTRL_W-1:0] bits_w;
    logic              maxed_q;

    for (genvar gi = 0; gi < CTRL_W; gi++) begin : g_bit
        bit_act_e act;
        logic     bit_q;

        assign act = bit_action(gi, len_i, fmin_i, fmax_i);

        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else begin
                case (act)
                    BIT_LOAD: bit_q <= sel_i[gi];
                    BIT_CLR:  bit_q <= 1'b0;
                    BIT_SET:  bit_q <= 1'b1;
                    default:  bit_q <= bit_q;
                endcase
            end
        end

        assign bits_w[gi] = bit_q;
    end

    // Extra gate step follows the force-high input, force-low has priority
    always_ff @(posedge clk) begin
        if (rst)
            maxed_q <= 1'b0;
        else
            maxed_q <= fmax_i & ~fmin_i;
    end

    assign ctrl_o = '{maxed: maxed_q, bits: bits_w};

endmodule

// File: rtl/tapdl_tap_decode.sv
module tapdl_tap_decode
    import tapdl_pkg::*;
#(
    parameter int MIN_DLY = 4,
    parameter int DW      = 8
) (
    input  ctrl_t         ctrl_i,
    output logic [DW-1:0] units_o
);

    int unsigned total;

    always_comb begin
        total = MIN_DLY + code_weight(ctrl_i.bits[SEL_W-1:0]);
        if (ctrl_i.maxed)
            total = total + EXTRA_UNITS;
        units_o = DW'(total);
    end

endmodule

// File: rtl/tapdl_shift_line.sv
module tapdl_shift_line #(
    parameter int SR_LEN = 131,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          din_i,
    input  logic [DW-1:0] tap_i,
    output logic          dout_o
);

    localparam int IW = (SR_LEN > 1) ? $clog2(SR_LEN) : 1;

    logic [SR_LEN-1:0] sr_q;
    logic              tap_bit;
    logic              dout_q;
    int                idx;

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else
            sr_q <= {sr_q[SR_LEN-2:0], din_i};
    end

    // Output register is the last stage, so a tap of D reads position D-2
    always_comb begin
        idx = int'(tap_i) - 2;
        if (idx >= 0 && idx < SR_LEN)
            tap_bit = sr_q[IW'(idx)];
        else
            tap_bit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout_q <= 1'b0;
        else
            dout_q <= en_i & tap_bit;
    end

    assign dout_o = dout_q;

endmodule

// File: rtl/tapdl_stage.sv
module tapdl_stage
    import tapdl_pkg::*;
#(
    parameter int MIN_DLY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              din_i,
    input  logic              len_i,
    input  logic              force_min_i,
    input  logic              force_max_i,
    input  logic [CTRL_W-1:0] sel_i,
    output logic              dout_o,
    output logic              cas_o,
    output logic              cas_n_o
);

    localparam int MAX_DLY = MIN_DLY + MAX_UNITS;
    localparam int SR_LEN  = MAX_DLY - 1;
    localparam int DW      = $clog2(MAX_DLY + 1);

    ctrl_t         ctrl;
    logic [DW-1:0] delay_units;
    logic          maxed;

    tapdl_ctrl_latch u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .len_i  (len_i),
        .fmin_i (force_min_i),
        .fmax_i (force_max_i),
        .sel_i  (sel_i),
        .ctrl_o (ctrl)
    );

    tapdl_tap_decode #(
        .MIN_DLY (MIN_DLY),
        .DW      (DW)
    ) u_decode (
        .ctrl_i  (ctrl),
        .units_o (delay_units)
    );

    tapdl_shift_line #(
        .SR_LEN (SR_LEN),
        .DW     (DW)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .din_i  (din_i),
        .tap_i  (delay_units),
        .dout_o (dout_o)
    );

    assign maxed   = ctrl.maxed;
    assign cas_o   = ctrl.bits[CAS_BIT];
    assign cas_n_o = ~ctrl.bits[CAS_BIT];

endmodule

// File: rtl/tapdl_stage_chk.sv
module tapdl_stage_chk
    import tapdl_pkg::*;
#(
    parameter int MIN_DLY = 4,
    parameter int DW      = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic              len_i,
    input logic              force_min_i,
    input logic              force_max_i,
    input logic [CTRL_W-1:0] sel_i,
    input logic              dout_o,
    input logic              cas_o,
    input logic              cas_n_o,
    input logic [DW-1:0]     delay_units,
    input logic              maxed
);

    localparam logic [DW-1:0] LO_D = DW'(MIN_DLY);
    localparam logic [DW-1:0] HI_D = DW'(MIN_DLY + MAX_UNITS);

    // R2: delay never leaves its legal window
    assert_delay_window_R2: assert property (@(posedge clk) disable iff (rst)
        (delay_units >= LO_D) && (delay_units <= HI_D));

    // R3: holding with no override keeps the delay fixed
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (len_i && !force_min_i && !force_max_i && !maxed) |=> $stable(delay_units));

    // R4: cascade output tracks the loaded bit 7
    assert_cas_track_R4: assert property (@(posedge clk) disable iff (rst)
        (!len_i && !force_min_i) |=> (cas_o == $past(sel_i[CAS_BIT])));

    // R4: cascade pair is complementary
    assert_cas_pair_R4: assert property (@(posedge clk) disable iff (rst)
        cas_o != cas_n_o);

    // R5: force-low gives minimum delay and clears cascade
    assert_force_min_R5: assert property (@(posedge clk) disable iff (rst)
        force_min_i |=> (delay_units == LO_D) && !cas_o);

    // R6: force-high alone gives the maximum delay
    assert_force_max_R6: assert property (@(posedge clk) disable iff (rst)
        (force_max_i && !force_min_i) |=> (delay_units == HI_D));

    // R7: disabled input keeps the output low
    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !dout_o);

endmodule

bind tapdl_stage tapdl_stage_chk #(
    .MIN_DLY (MIN_DLY),
    .DW      (DW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .len_i       (len_i),
    .force_min_i (force_min_i),
    .force_max_i (force_max_i),
    .sel_i       (sel_i),
    .dout_o      (dout_o),
    .cas_o       (cas_o),
    .cas_n_o     (cas_n_o),
    .delay_units (delay_units),
    .maxed       (maxed)
);

// File: tb/tapdl_stage_bench.sv
module tapdl_stage_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_DLY    = 4;
    localparam int FLUSH      = MIN_DLY + 136;
    localparam int LIMIT      = 2 * MIN_DLY + 300;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;

    // stand-alone stage
    logic       en_s = 1'b1, din_s = 1'b0, len_s = 1'b0;
    logic       fmin_s = 1'b0, fmax_s = 1'b0;
    logic [7:0] sel_s = 8'd0;
    logic       dout_s, cas_s, casn_s;

    // chained pair
    logic       din_c = 1'b0;
    logic [7:0] ext_c = 8'd0;
    logic       dout_a, cas_a, casn_a, dout_c, cas_b, casn_b;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tapdl_stage #(.MIN_DLY(MIN_DLY)) u_tapdl_stage (
        .clk(clk), .rst(rst), .en_i(en_s), .din_i(din_s), .len_i(len_s),
        .force_min_i(fmin_s), .force_max_i(fmax_s), .sel_i(sel_s),
        .dout_o(dout_s), .cas_o(cas_s), .cas_n_o(casn_s)
    );

    tapdl_stage #(.MIN_DLY(MIN_DLY)) u_tapdl_stage_hi (
        .clk(clk), .rst(rst), .en_i(1'b1), .din_i(din_c), .len_i(1'b0),
        .force_min_i(1'b0), .force_max_i(cas_a), .sel_i(ext_c),
        .dout_o(dout_a), .cas_o(cas_a), .cas_n_o(casn_a)
    );

    tapdl_stage #(.MIN_DLY(MIN_DLY)) u_tapdl_stage_lo (
        .clk(clk), .rst(rst), .en_i(1'b1), .din_i(dout_a), .len_i(1'b0),
        .force_min_i(casn_a), .force_max_i(1'b0), .sel_i({1'b0, ext_c[6:0]}),
        .dout_o(dout_c), .cas_o(cas_b), .cas_n_o(casn_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse the input one cycle and count cycles until the output rises
    task automatic measure(input bit use_chain, output int d);
        int cnt;
        bit seen;
        cnt  = 0;
        seen = 1'b0;
        @(negedge clk);
        if (use_chain) din_c = 1'b1; else din_s = 1'b1;
        while (!seen && cnt < LIMIT) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            din_c = 1'b0;
            din_s = 1'b0;
            seen  = use_chain ? dout_c : dout_s;
        end
        d = seen ? cnt : -1;
        repeat (FLUSH) @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_R8();
        int d;
        @(negedge clk);
        rst   = 1'b1;
        len_s = 1'b1;
        sel_s = 8'hB7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 dout after reset", dout_s, 0);
        chk("R8 cas after reset", cas_s, 0);
        chk("R8 cas_n after reset", casn_s, 1);
        measure(1'b0, d);
        chk("R8 delay after reset", d, MIN_DLY);
        len_s = 1'b0;
    endtask

    task automatic t_weights_R1();
        int d;
        int codes[6] = '{0, 1, 2, 5, 64, 85};
        foreach (codes[k]) begin
            @(negedge clk);
            sel_s = 8'(codes[k]);
            settle();
            measure(1'b0, d);
            chk($sformatf("R1 code %0d", codes[k]), d, MIN_DLY + codes[k]);
        end
    endtask

    task automatic t_all_ones_R2();
        int d;
        @(negedge clk);
        sel_s = 8'h7F;
        settle();
        measure(1'b0, d);
        chk("R2 all ones", d, MIN_DLY + 127);
    endtask

    task automatic t_hold_R3();
        int d;
        @(negedge clk);
        len_s = 1'b0;
        sel_s = 8'd20;
        settle();
        len_s = 1'b1;
        sel_s = 8'd77;
        settle();
        measure(1'b0, d);
        chk("R3 held code ignores bus", d, MIN_DLY + 20);
        @(negedge clk);
        len_s = 1'b0;
        settle();
        measure(1'b0, d);
        chk("R3 reload after release", d, MIN_DLY + 77);
    endtask

    task automatic t_cascade_R4();
        int d;
        @(negedge clk);
        sel_s = 8'h89;
        @(negedge clk);
        chk("R4 cas set after one edge", cas_s, 1);
        chk("R4 cas_n cleared", casn_s, 0);
        settle();
        measure(1'b0, d);
        chk("R4 bit7 adds no delay", d, MIN_DLY + 9);
        @(negedge clk);
        sel_s = 8'h09;
        @(negedge clk);
        chk("R4 cas cleared", cas_s, 0);
        chk("R4 cas_n set", casn_s, 1);
    endtask

    task automatic t_force_min_R5();
        int d;
        @(negedge clk);
        sel_s = 8'hE4;
        settle();
        len_s = 1'b1;
        fmin_s = 1'b1;
        sel_s = 8'h7F;
        settle();
        chk("R5 cas cleared by force", cas_s, 0);
        measure(1'b0, d);
        chk("R5 forced minimum", d, MIN_DLY);
        @(negedge clk);
        fmin_s = 1'b0;
        settle();
        measure(1'b0, d);
        chk("R5 cleared word kept under hold", d, MIN_DLY);
        @(negedge clk);
        fmin_s = 1'b1;
        fmax_s = 1'b1;
        settle();
        measure(1'b0, d);
        chk("R5 force-low wins over force-high", d, MIN_DLY);
        @(negedge clk);
        fmin_s = 1'b0;
        fmax_s = 1'b0;
        len_s  = 1'b0;
    endtask

    task automatic t_force_max_R6();
        int d;
        @(negedge clk);
        sel_s  = 8'h03;
        fmax_s = 1'b1;
        settle();
        chk("R6 bit7 follows bus", cas_s, 0);
        measure(1'b0, d);
        chk("R6 forced maximum, code 3", d, MIN_DLY + 128);
        @(negedge clk);
        sel_s = 8'hFF;
        settle();
        chk("R6 bit7 still loads", cas_s, 1);
        measure(1'b0, d);
        chk("R6 forced maximum, code 127", d, MIN_DLY + 128);
        @(negedge clk);
        fmax_s = 1'b0;
        sel_s  = 8'd10;
        settle();
        measure(1'b0, d);
        chk("R6 release returns to bus", d, MIN_DLY + 10);
    endtask

    task automatic t_enable_R7();
        int d;
        @(negedge clk);
        sel_s = 8'd6;
        en_s  = 1'b0;
        settle();
        measure(1'b0, d);
        chk("R7 disabled output stays low", d, -1);
        @(negedge clk);
        en_s = 1'b1;
        settle();
        measure(1'b0, d);
        chk("R7 enabled output follows", d, MIN_DLY + 6);
    endtask

    task automatic t_chain_R9();
        int d;
        int prev;
        int bad_step;
        prev     = -1;
        bad_step = 0;
        for (int c = 0; c < 256; c++) begin
            @(negedge clk);
            ext_c = 8'(c);
            settle();
            measure(1'b1, d);
            chk($sformatf("R9 chained code %0d", c), d, 2 * MIN_DLY + c);
            if (c > 0 && d - prev != 1) bad_step++;
            prev = d;
        end
        chk("R9 one unit per step", bad_step, 0);
    endtask

    initial begin
        t_reset_R8();
        t_weights_R1();
        t_all_ones_R2();
        t_hold_R3();
        t_cascade_R4();
        t_force_min_R5();
        t_force_max_R6();
        t_enable_R7();
        t_chain_R9();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule